// File: doc/BRIEF.md
# Fused Immediate-Operand ALU Stage

This block is one execute stage of an 8-bit accumulator datapath. It handles a small group of immediate-mode opcodes. Each opcode joins two plain operations into a single step: an AND followed by a right rotate, an AND that also loads the carry, a masked compare that also writes back the difference, or a second encoding of subtract-with-borrow. The caller supplies the opcode, the current A and X registers, the immediate byte and the incoming N, V, Z and C flags, and raises `in_valid` for one cycle.

On the next clock edge the stage registers the new A, the new X and the four flags, and raises `out_valid` for one cycle. A flag that the selected opcode does not define keeps the value it arrived with. When the opcode falls outside the supported group, every value passes through unchanged. Decimal arithmetic is not modelled, and operands always come in on the ports; the stage never fetches from memory.

Top module: `fused_imm_alu`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it goes high, `out_valid` is 0 and `a_out`, `x_out`, `n_out`, `v_out`, `z_out` and `c_out` are all 0.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. When `in_valid` is low, all registered outputs keep their values.
- R3: Opcode 0x0B writes `a_in & imm` to A. N and C both take bit 7 of that result, Z is set when the result is zero, and V and X are unchanged.
- R4: Opcode 0x2B produces exactly the same A, X and flags as 0x0B.
- R5: Opcode 0x6B forms t = `a_in & imm` and writes r = {`c_in`, t[7:1]} to A. C becomes r[6], V becomes r[6] XOR r[5], N becomes r[7] and Z is set when r is zero. X is unchanged.
- R6: Opcode 0xCB writes (`a_in & x_in`) − `imm` (mod 256) to X. C is set when (`a_in & x_in`) ≥ `imm` as unsigned values, and N and Z follow the new X. `c_in` has no effect. A and V are unchanged.
- R7: Opcode 0xEB writes `a_in` − `imm` − (1 − `c_in`) (mod 256) to A. C is set when no borrow occurs, V is set on two's-complement overflow, and N and Z follow the new A. X is unchanged.
- R8: Any other opcode leaves A, X, N, V, Z and C equal to their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: operands are present this cycle |
| opcode | input | 8 | Operation select |
| a_in | input | 8 | Accumulator value |
| x_in | input | 8 | Index register value |
| imm | input | 8 | Immediate operand |
| n_in | input | 1 | Incoming negative flag |
| v_in | input | 1 | Incoming overflow flag |
| z_in | input | 1 | Incoming zero flag |
| c_in | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result is valid this cycle |
| a_out | output | 8 | Updated accumulator |
| x_out | output | 8 | Updated index register |
| n_out | output | 1 | Updated negative flag |
| v_out | output | 1 | Updated overflow flag |
| z_out | output | 1 | Updated zero flag |
| c_out | output | 1 | Updated carry flag |

## Verification
The stage has only one register level, so any fault in the decode, the operand mux or the subtractor reaches the ports in the cycle straight after the strobe. It shows up there as a wrong byte in A or X, or as a wrong flag bit. Two faults need specific stimulus to be seen. A swapped carry or borrow sense shows only when operands sit on both sides of the unsigned compare. An error in the rotate's V and C bits shows only when bits 5 and 6 of the rotated value differ. The every-operand sweep covers both of these cases for each opcode in the group. A wrong hold or pass-through path shows up as outputs that change in idle cycles, or that change for opcodes outside the group.

// File: rtl/fia_pkg.sv
package fia_pkg;
  localparam int unsigned OPW = 8;

  localparam logic [OPW-1:0] OPC_AND_CARRY  = 8'h0B;
  localparam logic [OPW-1:0] OPC_AND_CARRY2 = 8'h2B;
  localparam logic [OPW-1:0] OPC_AND_ROR    = 8'h6B;
  localparam logic [OPW-1:0] OPC_MASK_SUB   = 8'hCB;
  localparam logic [OPW-1:0] OPC_SUB_BORROW = 8'hEB;

  typedef enum logic [2:0] {
    K_PASS,
    K_AND_CARRY,
    K_AND_ROR,
    K_MASK_SUB,
    K_SUB_BORROW
  } op_kind_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/fia_decode.sv
module fia_decode
  import fia_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  output op_kind_e       kind
);
  always_comb begin
    unique case (opcode)
      OPC_AND_CARRY,
      OPC_AND_CARRY2: kind = K_AND_CARRY;
      OPC_AND_ROR:    kind = K_AND_ROR;
      OPC_MASK_SUB:   kind = K_MASK_SUB;
      OPC_SUB_BORROW: kind = K_SUB_BORROW;
      default:        kind = K_PASS;
    endcase
  end
endmodule

// File: rtl/fia_logic_unit.sv
module fia_logic_unit #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_val,
  input  logic [W-1:0] mask,
  input  logic         rot_in,
  output logic [W-1:0] and_res,
  output logic [W-1:0] ror_res,
  output logic         ror_c,
  output logic         ror_v
);
  localparam int unsigned B_HI  = W - 2;
  localparam int unsigned B_MID = W - 3;

  function automatic logic [W-1:0] f_rot_right(input logic [W-1:0] v, input logic fill);
    return {fill, v[W-1:1]};
  endfunction

  assign and_res = a_val & mask;
  assign ror_res = f_rot_right(and_res, rot_in);
  assign ror_c   = ror_res[B_HI];
  assign ror_v   = ror_res[B_HI] ^ ror_res[B_MID];
endmodule

// File: rtl/fia_sub_unit.sv
module fia_sub_unit #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic         no_borrow_in,
  output logic [W-1:0] diff,
  output logic         no_borrow_out,
  output logic         ovf
);
  // Subtraction done as lhs + ~rhs + carry; a carry out of the top bit means no borrow.
  function automatic logic [W:0] f_sub_wide(input logic [W-1:0] l, input logic [W-1:0] r,
                                            input logic cin);
    return {1'b0, l} + {1'b0, ~r} + {{W{1'b0}}, cin};
  endfunction

  logic [W:0] wide;

  assign wide          = f_sub_wide(lhs, rhs, no_borrow_in);
  assign diff          = wide[W-1:0];
  assign no_borrow_out = wide[W];
  assign ovf           = (lhs[W-1] ^ rhs[W-1]) & (lhs[W-1] ^ wide[W-1]);
endmodule

// File: rtl/fused_imm_alu.sv
module fused_imm_alu
  import fia_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [OPW-1:0] opcode,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   x_in,
  input  logic [W-1:0]   imm,
  input  logic           n_in,
  input  logic           v_in,
  input  logic           z_in,
  input  logic           c_in,
  output logic           out_valid,
  output logic [W-1:0]   a_out,
  output logic [W-1:0]   x_out,
  output logic           n_out,
  output logic           v_out,
  output logic           z_out,
  output logic           c_out
);
  localparam int unsigned MSB = W - 1;

  op_kind_e    kind;
  logic [W-1:0] and_res, ror_res;
  logic         ror_c, ror_v;
  logic [W-1:0] sub_lhs, sub_diff;
  logic         sub_cin, sub_nb, sub_ovf;

  // Named internal events, observed by the checker.
  logic [W-1:0] nz_src;
  logic         op_known;

  logic [W-1:0] nxt_a, nxt_x;
  flags_t       nxt_f, in_f, q_f;

  fia_decode u_dec (
    .opcode (opcode),
    .kind   (kind)
  );

  fia_logic_unit #(.W(W)) u_logic (
    .a_val   (a_in),
    .mask    (imm),
    .rot_in  (c_in),
    .and_res (and_res),
    .ror_res (ror_res),
    .ror_c   (ror_c),
    .ror_v   (ror_v)
  );

  // One subtractor serves both the masked compare and the borrow subtract.
  assign sub_lhs = (kind == K_MASK_SUB) ? (a_in & x_in) : a_in;
  assign sub_cin = (kind == K_MASK_SUB) ? 1'b1 : c_in;

  fia_sub_unit #(.W(W)) u_sub (
    .lhs           (sub_lhs),
    .rhs           (imm),
    .no_borrow_in  (sub_cin),
    .diff          (sub_diff),
    .no_borrow_out (sub_nb),
    .ovf           (sub_ovf)
  );

  assign in_f     = '{n: n_in, v: v_in, z: z_in, c: c_in};
  assign op_known = (kind != K_PASS);

  always_comb begin
    nxt_a  = a_in;
    nxt_x  = x_in;
    nxt_f  = in_f;
    nz_src = a_in;
    unique case (kind)
      K_AND_CARRY: begin
        nxt_a   = and_res;
        nz_src  = and_res;
        nxt_f.c = and_res[MSB];
      end
      K_AND_ROR: begin
        nxt_a   = ror_res;
        nz_src  = ror_res;
        nxt_f.c = ror_c;
        nxt_f.v = ror_v;
      end
      K_MASK_SUB: begin
        nxt_x   = sub_diff;
        nz_src  = sub_diff;
        nxt_f.c = sub_nb;
      end
      K_SUB_BORROW: begin
        nxt_a   = sub_diff;
        nz_src  = sub_diff;
        nxt_f.c = sub_nb;
        nxt_f.v = sub_ovf;
      end
      default: ;
    endcase
    if (op_known) begin
      nxt_f.n = nz_src[MSB];
      nxt_f.z = (nz_src == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      a_out     <= '0;
      x_out     <= '0;
      q_f       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        a_out <= nxt_a;
        x_out <= nxt_x;
        q_f   <= nxt_f;
      end
    end
  end

  assign n_out = q_f.n;
  assign v_out = q_f.v;
  assign z_out = q_f.z;
  assign c_out = q_f.c;
endmodule

// File: rtl/fused_imm_alu_chk.sv
module fused_imm_alu_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [7:0]   opcode,
  input logic [W-1:0] a_in,
  input logic [W-1:0] x_in,
  input logic [W-1:0] imm,
  input logic         n_in,
  input logic         v_in,
  input logic         z_in,
  input logic         c_in,
  input logic         out_valid,
  input logic [W-1:0] a_out,
  input logic [W-1:0] x_out,
  input logic         n_out,
  input logic         v_out,
  input logic         z_out,
  input logic         c_out,
  input logic [W-1:0] nz_src,
  input logic         op_known
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && a_out == '0 && x_out == '0 && !n_out && !v_out && !z_out && !c_out)); // R1

  AST_STROBE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(a_out) && $stable(x_out)
                   && $stable({n_out, v_out, z_out, c_out}))); // R2

  AST_NZ_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_known) |=> (z_out == ($past(nz_src) == '0) && n_out == $past(nz_src[W-1]))); // R3

  AST_AND_CARRY_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 8'h0B) |=> (c_out == a_out[W-1] && v_out == $past(v_in)
                                       && x_out == $past(x_in))); // R3

  AST_AND_CARRY_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 8'h2B) |=> (a_out == $past(a_in & imm) && c_out == a_out[W-1])); // R4

  AST_ROR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 8'h6B) |=> (a_out[W-1] == $past(c_in) && c_out == a_out[W-2]
                                       && v_out == (a_out[W-2] ^ a_out[W-3]))); // R5

  AST_MASK_CMP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 8'hCB) |=> (c_out == ($past(a_in & x_in) >= $past(imm))
                                       && a_out == $past(a_in) && v_out == $past(v_in))); // R6

  AST_SUB_KEEPS_X: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 8'hEB) |=> (x_out == $past(x_in))); // R7

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_known) |=> (a_out == $past(a_in) && x_out == $past(x_in)
                                 && {n_out, v_out, z_out, c_out} == $past({n_in, v_in, z_in, c_in}))); // R8
endmodule

bind fused_imm_alu fused_imm_alu_chk #(.W(W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .opcode    (opcode),
  .a_in      (a_in),
  .x_in      (x_in),
  .imm       (imm),
  .n_in      (n_in),
  .v_in      (v_in),
  .z_in      (z_in),
  .c_in      (c_in),
  .out_valid (out_valid),
  .a_out     (a_out),
  .x_out     (x_out),
  .n_out     (n_out),
  .v_out     (v_out),
  .z_out     (z_out),
  .c_out     (c_out),
  .nz_src    (nz_src),
  .op_known  (op_known)
);

// File: tb/fused_imm_alu_tb_top.sv
`timescale 1ns/1ps
module fused_imm_alu_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] opcode = '0, a_in = '0, x_in = '0, imm = '0;
  logic       n_in = 1'b0, v_in = 1'b0, z_in = 1'b0, c_in = 1'b0;
  logic       out_valid;
  logic [7:0] a_out, x_out;
  logic       n_out, v_out, z_out, c_out;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  always #2 clk = ~clk;

  fused_imm_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .a_in(a_in), .x_in(x_in), .imm(imm),
    .n_in(n_in), .v_in(v_in), .z_in(z_in), .c_in(c_in),
    .out_valid(out_valid), .a_out(a_out), .x_out(x_out),
    .n_out(n_out), .v_out(v_out), .z_out(z_out), .c_out(c_out)
  );

  // {op, a, x, imm, nvzc_in, exp_a, exp_x, exp_nvzc}
  localparam int NV = 13;
  localparam logic [55:0] VEC [NV] = '{
    {8'h0B, 8'hF0, 8'h12, 8'h8F, 4'b0100, 8'h80, 8'h12, 4'b1101},
    {8'h2B, 8'h0F, 8'h12, 8'hF0, 4'b0001, 8'h00, 8'h12, 4'b0010},
    {8'h2B, 8'hFF, 8'h00, 8'h80, 4'b0000, 8'h80, 8'h00, 4'b1001},
    {8'h6B, 8'hFF, 8'h00, 8'hFF, 4'b0001, 8'hFF, 8'h00, 4'b1001},
    {8'h6B, 8'hFF, 8'h00, 8'hC0, 4'b0000, 8'h60, 8'h00, 4'b0001},
    {8'h6B, 8'hFF, 8'h00, 8'h40, 4'b0000, 8'h20, 8'h00, 4'b0100},
    {8'h6B, 8'h01, 8'h00, 8'h01, 4'b0000, 8'h00, 8'h00, 4'b0010},
    {8'hCB, 8'hF0, 8'h3C, 8'h30, 4'b0100, 8'hF0, 8'h00, 4'b0111},
    {8'hCB, 8'hFF, 8'h10, 8'h20, 4'b0001, 8'hFF, 8'hF0, 4'b1000},
    {8'hEB, 8'h50, 8'h00, 8'hB0, 4'b0001, 8'hA0, 8'h00, 4'b1100},
    {8'hEB, 8'h00, 8'h00, 8'h00, 4'b0000, 8'hFF, 8'h00, 4'b1000},
    {8'hEB, 8'h80, 8'h00, 8'h01, 4'b0001, 8'h7F, 8'h00, 4'b0101},
    {8'hA9, 8'h12, 8'h34, 8'h56, 4'b1011, 8'h12, 8'h34, 4'b1011}
  };

  function automatic string req_of(input logic [7:0] op);
    case (op)
      8'h0B:   return "R3";
      8'h2B:   return "R4";
      8'h6B:   return "R5";
      8'hCB:   return "R6";
      8'hEB:   return "R7";
      default: return "R8";
    endcase
  endfunction

  // Independent reference: integer arithmetic, result {a, x, n, v, z, c}.
  function automatic logic [19:0] model(input logic [7:0] op, input logic [7:0] a,
                                        input logic [7:0] x, input logic [7:0] m,
                                        input logic [3:0] f);
    logic [7:0] ra = a, rx = x, t;
    logic n = f[3], v = f[2], z = f[1], c = f[0];
    int d;
    case (op)
      8'h0B, 8'h2B: begin
        ra = a & m; c = (ra >= 8'h80); n = c; z = (ra == 0);
      end
      8'h6B: begin
        t  = a & m;
        d  = int'(t) / 2 + (f[0] ? 128 : 0);
        ra = d[7:0];
        c  = ((d / 64) % 2) == 1;
        v  = c != (((d / 32) % 2) == 1);
        n  = d >= 128; z = (d == 0);
      end
      8'hCB: begin
        d  = int'(a & x) - int'(m);
        rx = d[7:0]; c = (d >= 0); n = rx[7]; z = (rx == 0);
      end
      8'hEB: begin
        d  = int'(a) - int'(m) - (f[0] ? 0 : 1);
        ra = d[7:0]; c = (d >= 0); n = ra[7]; z = (ra == 0);
        d  = int'($signed(a)) - int'($signed(m)) - (f[0] ? 0 : 1);
        v  = (d < -128) || (d > 127);
      end
      default: ;
    endcase
    return {ra, rx, n, v, z, c};
  endfunction

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got a=%h x=%h nvzc=%b, want a=%h x=%h nvzc=%b",
               req, act[19:12], act[11:4], act[3:0], exp[19:12], exp[11:4], exp[3:0]);
    end
  endtask

  function automatic logic [19:0] outs();
    return {a_out, x_out, n_out, v_out, z_out, c_out};
  endfunction

  // Drive one strobe at a falling edge; the result is registered on the next rising edge.
  task automatic apply(input logic [7:0] op, input logic [7:0] a, input logic [7:0] x,
                       input logic [7:0] m, input logic [3:0] f);
    @(negedge clk);
    opcode = op; a_in = a; x_in = x; imm = m;
    {n_in, v_in, z_in, c_in} = f;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    n_checks++;
    if (out_valid !== 1'b1) begin
      n_fails++;
      $display("FAIL R2: out_valid=%b after strobe, want 1", out_valid);
    end
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_fails++;
        $display("FAIL watchdog: run exceeded %0d cycles", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
      end
    end
  end

  initial begin : main
    logic [19:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {out_valid, outs()}, 21'h0);
    rst_n = 1'b1;

    // Table walk: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][55:48], VEC[i][47:40], VEC[i][39:32], VEC[i][31:24], VEC[i][23:20]);
      check(req_of(VEC[i][55:48]), outs(), VEC[i][19:0]);
    end

    // Every immediate value across an A/X/carry sweep for each fused opcode.
    begin : sweep
      logic [7:0] ops [5] = '{8'h0B, 8'h2B, 8'h6B, 8'hCB, 8'hEB};
      logic [7:0] as  [6] = '{8'h00, 8'h55, 8'hAA, 8'hFF, 8'h80, 8'h7F};
      logic [7:0] xs  [2] = '{8'hFF, 8'h3C};
      for (int o = 0; o < 5; o++)
        for (int ia = 0; ia < 6; ia++)
          for (int ix = 0; ix < 2; ix++)
            for (int ci = 0; ci < 2; ci++)
              for (int m = 0; m < 256; m++) begin
                logic [3:0] f = {1'b0, ci[0] ^ m[0], 1'b0, ci[0]};
                apply(ops[o], as[ia], xs[ix], m[7:0], f);
                check(req_of(ops[o]), outs(), model(ops[o], as[ia], xs[ix], m[7:0], f));
              end
    end

    // R6: carry-in has no effect on the masked compare
    apply(8'hCB, 8'hF0, 8'h3C, 8'h31, 4'b0001);
    held = outs();
    apply(8'hCB, 8'hF0, 8'h3C, 8'h31, 4'b0000);
    check("R6", outs(), {held[19:1], 1'b0} | {19'h0, held[0]});

    // R2: idle cycles hold everything and drop out_valid
    held = outs();
    @(negedge clk);
    @(negedge clk);
    check("R2", {out_valid, outs()}, {1'b0, held});

    // R1: reset in mid-run clears outputs
    apply(8'h0B, 8'hFF, 8'hFF, 8'hFF, 4'b1111);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", {out_valid, outs()}, 21'h0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule